// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter that sits on a processor bus like a memory location. The host starts a conversion by pulsing an active-low write strobe with chip select low. The block then resolves the code one bit at a time, most significant bit first. It drives a trial code to an external resistor ladder and samples a single comparator bit for each decision. When the last bit is settled, it loads the result register and pulls an active-low interrupt. A read with chip select low enables the data bus drivers and acknowledges the interrupt.

The bus strobes are asynchronous to the conversion clock. Each one passes through a two-flop synchroniser before its edges are detected. Holding write and chip select low keeps the sequencer parked for as long as they stay low. The search begins after the write rises. Feeding the interrupt straight back into the write input, with chip select held low, makes the block convert continuously.

The timing is fixed. A conversion lasts exactly 71 clock periods: 2 synchroniser stages, a 4-cycle alignment wait, 8 cycles for each of the 8 bits, and the transfer edge.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, intr_n is 1, data_oe is 0, trial_code is 0 and data_out is 0.
- R2: While cs_n and wr_n are both low, no search runs, for any duration: trial_code stays 0 and intr_n stays 1.
- R3: A rising wr_n with cs_n low starts a conversion. A write pulse with cs_n high starts nothing.
- R4: intr_n goes low on the 71st rising clock edge, counting the first edge that samples wr_n high. It is still high after the 70th.
- R5: The search goes from MSB to LSB with 8 cycles per bit. trial_code is 8'h80 after the 7th edge. After the 15th edge it is the decided bit 7 OR 8'h40.
- R6: With an ideal comparator (cmp_hi = 1 when vin_p - vin_n >= trial_code), the result equals vin_p - vin_n.
- R7: When the negative input is at or above the positive input, the result is 8'h00.
- R8: data_out keeps the previous result until a conversion completes. It is loaded on the same edge that pulls intr_n low.
- R9: A falling rd_n with cs_n low sets intr_n back to 1 three edges later. A read with cs_n high leaves intr_n low.
- R10: A falling wr_n with cs_n low sets intr_n back to 1 three edges later.
- R11: data_oe is 1 exactly while cs_n and rd_n are both low.
- R12: If a clearing strobe edge and the end of a conversion land on the same edge, the end of conversion wins: intr_n goes low and the new result is loaded.
- R13: With wr_n tied to intr_n and cs_n low, conversions repeat every 74 clock periods and each one delivers the correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| wr_n | input | 1 | Active-low write/start strobe (asynchronous) |
| rd_n | input | 1 | Active-low read strobe (asynchronous) |
| cmp_hi | input | 1 | Comparator: 1 when the analog input is at or above the trial level |
| trial_code | output | 8 | Trial code to the external ladder; 0 when idle |
| data_out | output | 8 | Result register value for the data bus |
| data_oe | output | 1 | Data bus driver enable |
| intr_n | output | 1 | Active-low end-of-conversion interrupt |

## Verification
The end of a conversion, which pulls the interrupt low, and a read acknowledge, which sets it high, can fall on the same clock edge. The bench provokes this by dropping the read strobe exactly three edges before the completion edge, allowing for the synchroniser delay. It then checks that the interrupt is low on that edge and that the bus shows the new result. The bench also checks this with an ideal comparator model that closes the loop, and with the interrupt fed back to the write strobe, where clear and restart come from the block's own output.

// File: rtl/sar_pkg.sv
// Shared definitions for the successive-approximation sequencer.
// Assumes a single clock domain for all internal logic.
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ALIGN  = 2'd1,
        ST_SEARCH = 2'd2
    } sar_state_e;

    // Bit positions of the bus strobes inside the synchroniser vector
    localparam int STB_CS = 0;
    localparam int STB_WR = 1;
    localparam int STB_RD = 2;
    localparam int STB_N  = 3;
endpackage

// File: rtl/sar_strobe_sync.sv
// Two-flop synchroniser plus one history flop per strobe.
// Produces synchronised levels and one-cycle rise/fall pulses.
// Assumes strobes idle high, so all flops reset to 1.
module sar_strobe_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] stg1, stg2, hist;

    for (genvar i = 0; i < N; i++) begin : g_chain
        // Purpose: metastability filter and edge history for strobe i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg1[i] <= 1'b1;
                stg2[i] <= 1'b1;
                hist[i] <= 1'b1;
            end else begin
                stg1[i] <= async_in[i];
                stg2[i] <= stg1[i];
                hist[i] <= stg2[i];
            end
        end
    end

    assign lvl  = stg2;
    assign rise = stg2 & ~hist;
    assign fall = ~stg2 & hist;
endmodule

// File: rtl/sar_seq.sv
// Bit-search sequencer: waits ALIGN_CYC cycles after a start, then
// spends BIT_CYC cycles per bit, sampling the comparator on the last cycle.
// Presents the final code with a one-cycle done pulse.
// Assumes cmp_hi is stable by the last cycle of each bit window.
module sar_seq
    import sar_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BIT_CYC   = 8,
    parameter int ALIGN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              start,
    input  logic              cmp_hi,
    output logic [DATA_W-1:0] trial_code,
    output logic [DATA_W-1:0] bit_mask,
    output logic              searching,
    output logic              done,
    output logic [DATA_W-1:0] final_code
);
    localparam int CNT_MAX = (BIT_CYC > ALIGN_CYC) ? BIT_CYC : ALIGN_CYC;
    localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [DATA_W-1:0] MSB = {1'b1, {(DATA_W-1){1'b0}}};

    sar_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] decided;
    logic              bit_end;

    // Purpose: keep or drop the bit under test from the comparator verdict
    always_comb begin
        decided = cmp_hi ? trial_code : (trial_code & ~bit_mask);
        bit_end = (state == ST_SEARCH) && (cnt == CNT_W'(BIT_CYC - 1));
    end

    assign searching  = (state == ST_SEARCH);
    assign done       = bit_end && bit_mask[0] && !hold;
    assign final_code = decided;

    // Purpose: state, cycle counter and trial register advance
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            bit_mask   <= '0;
            trial_code <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) state <= ST_ALIGN;
                end
                ST_ALIGN: begin
                    if (cnt == CNT_W'(ALIGN_CYC - 1)) begin
                        state      <= ST_SEARCH;
                        cnt        <= '0;
                        bit_mask   <= MSB;
                        trial_code <= MSB;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SEARCH: begin
                    if (bit_end) begin
                        cnt <= '0;
                        if (bit_mask[0]) begin
                            state      <= ST_IDLE;
                            bit_mask   <= '0;
                            trial_code <= '0;
                        end else begin
                            bit_mask   <= bit_mask >> 1;
                            trial_code <= decided | (bit_mask >> 1);
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_result.sv
// Result register and active-low interrupt.
// Loads the result and asserts the interrupt on done; otherwise a clear
// request or the hold condition deasserts the interrupt. Done has priority.
module sar_result #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] final_code,
    input  logic              clr,
    input  logic              hold,
    output logic [DATA_W-1:0] result,
    output logic              intr_n
);
    // Purpose: capture the finished code and manage the interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            intr_n <= 1'b1;
        end else if (done) begin
            result <= final_code;
            intr_n <= 1'b0;
        end else if (clr || hold) begin
            intr_n <= 1'b1;
        end
    end
endmodule

// File: rtl/sar_conv_ctrl.sv
// Top: bus-facing successive-approximation conversion controller.
// Synchronises the bus strobes, decodes hold/start/clear, runs the
// sequencer and owns the result register. The bus enable follows the
// raw chip select and read pins without delay.
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BIT_CYC   = 8,
    parameter int ALIGN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              cmp_hi,
    output logic [DATA_W-1:0] trial_code,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              intr_n
);
    logic [STB_N-1:0]  stb_lvl, stb_rise, stb_fall;
    logic              hold, start, clr, done, searching;
    logic [DATA_W-1:0] bit_mask, final_code;

    sar_strobe_sync #(.N(STB_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({rd_n, wr_n, cs_n}),
        .lvl      (stb_lvl),
        .rise     (stb_rise),
        .fall     (stb_fall)
    );

    // Purpose: decode the synchronised strobes into control events
    always_comb begin
        hold  = !stb_lvl[STB_CS] && !stb_lvl[STB_WR];
        start = !stb_lvl[STB_CS] && stb_rise[STB_WR];
        clr   = !stb_lvl[STB_CS] && (stb_fall[STB_WR] || stb_fall[STB_RD]);
    end

    sar_seq #(
        .DATA_W    (DATA_W),
        .BIT_CYC   (BIT_CYC),
        .ALIGN_CYC (ALIGN_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .start      (start),
        .cmp_hi     (cmp_hi),
        .trial_code (trial_code),
        .bit_mask   (bit_mask),
        .searching  (searching),
        .done       (done),
        .final_code (final_code)
    );

    sar_result #(.DATA_W(DATA_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .final_code (final_code),
        .clr        (clr),
        .hold       (hold),
        .result     (data_out),
        .intr_n     (intr_n)
    );

    assign data_oe = !cs_n && !rd_n;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
// Checker for sar_conv_ctrl, bound to every instance of the top.
module sar_conv_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              done,
    input logic              searching,
    input logic [DATA_W-1:0] bit_mask,
    input logic [DATA_W-1:0] result,
    input logic [DATA_W-1:0] trial_code,
    input logic              intr_n
);
    localparam logic [DATA_W-1:0] MSB = {1'b1, {(DATA_W-1){1'b0}}};

    a_r2_hold_parks: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (intr_n && trial_code == '0));

    a_r5_search_opens_msb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(searching) |-> (trial_code == MSB));

    a_r5_single_bit_under_test: assert property (@(posedge clk) disable iff (!rst_n)
        searching |-> $onehot(bit_mask));

    a_r8_result_moves_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(intr_n));

    a_r12_done_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !intr_n);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .done       (done),
    .searching  (searching),
    .bit_mask   (bit_mask),
    .result     (data_out),
    .trial_code (trial_code),
    .intr_n     (intr_n)
);

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_drv = 1'b1, rd_n = 1'b1, tie = 1'b0;
    logic       wr_n, cmp_hi, data_oe, intr_n;
    logic [7:0] trial_code, data_out;
    logic [7:0] vin_p = 8'd0, vin_n = 8'd0;
    int         checks = 0, fails = 0;

    always #10 clk = ~clk;

    assign wr_n = tie ? intr_n : wr_drv;

    // Ideal comparator closing the loop
    always_comb cmp_hi = (int'(vin_p) - int'(vin_n)) >= int'(trial_code);

    sar_conv_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .cmp_hi(cmp_hi), .trial_code(trial_code), .data_out(data_out),
        .data_oe(data_oe), .intr_n(intr_n)
    );

    function automatic logic [7:0] expect_code(input logic [7:0] p, input logic [7:0] n);
        return (p > n) ? p - n : 8'd0;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_conv(input logic [7:0] p, input logic [7:0] n);
        @(negedge clk);
        vin_p = p; vin_n = n; cs_n = 1'b0; wr_drv = 1'b0;
        adv(4);
        wr_drv = 1'b1;
    endtask

    task automatic t_reset;
        adv(3);
        rst_n = 1'b1;
        adv(1);
        chk(intr_n == 1'b1, "R1 intr_n", intr_n, 1);
        chk(data_oe == 1'b0, "R1 data_oe", data_oe, 0);
        chk(trial_code == 8'd0, "R1 trial_code", trial_code, 0);
        chk(data_out == 8'd0, "R1 data_out", data_out, 0);
    endtask

    task automatic t_hold_and_deselect;
        vin_p = 8'd90; vin_n = 8'd0;
        cs_n = 1'b0; wr_drv = 1'b0;
        for (int i = 0; i < 4; i++) begin
            adv(30);
            chk(trial_code == 8'd0, "R2 trial during hold", trial_code, 0);
            chk(intr_n == 1'b1, "R2 intr during hold", intr_n, 1);
        end
        cs_n = 1'b1;
        adv(4);
        wr_drv = 1'b1;
        adv(12);
        chk(trial_code == 8'd0, "R3 no start when deselected", trial_code, 0);
        adv(80);
        chk(intr_n == 1'b1, "R3 no completion when deselected", intr_n, 1);
    endtask

    task automatic t_timed_conv(input logic [7:0] p, input logic [7:0] n);
        logic [7:0] e;
        e = expect_code(p, n);
        start_conv(p, n);
        adv(6);
        chk(trial_code == 8'd0, "R5 trial before search", trial_code, 0);
        adv(1);
        chk(trial_code == 8'h80, "R5 first trial MSB", trial_code, 8'h80);
        adv(8);
        chk(trial_code == ((e & 8'h80) | 8'h40), "R5 second trial",
            trial_code, (e & 8'h80) | 8'h40);
        adv(55);
        chk(intr_n == 1'b1, "R4 intr still high at edge 70", intr_n, 1);
        adv(1);
        chk(intr_n == 1'b0, "R4 intr low at edge 71", intr_n, 0);
        rd_n = 1'b0;
        #1;
        chk(data_oe == 1'b1, "R11 oe with cs and rd low", data_oe, 1);
        chk(data_out == e, (e == 0) ? "R7 clamped result" : "R6 result", data_out, e);
        adv(2);
        chk(intr_n == 1'b0, "R9 intr before sync delay", intr_n, 0);
        adv(1);
        chk(intr_n == 1'b1, "R9 read clears intr", intr_n, 1);
        rd_n = 1'b1;
        #1;
        chk(data_oe == 1'b0, "R11 oe off after read", data_oe, 0);
    endtask

    task automatic t_quick_conv(input logic [7:0] p, input logic [7:0] n);
        logic [7:0] e;
        e = expect_code(p, n);
        start_conv(p, n);
        adv(71);
        chk(intr_n == 1'b0, "R4 completion", intr_n, 0);
        chk(data_out == e, (e == 0) ? "R7 clamped result" : "R6 result", data_out, e);
    endtask

    task automatic t_hold_result;
        logic [7:0] old_v;
        t_quick_conv(8'd77, 8'd10);
        old_v = data_out;
        start_conv(8'd200, 8'd3);
        adv(40);
        rd_n = 1'b0;
        #1;
        chk(data_out == old_v, "R8 old result during conversion", data_out, old_v);
        rd_n = 1'b1;
        adv(30);
        chk(data_out == old_v, "R8 old result one edge before done", data_out, old_v);
        adv(1);
        chk(data_out == 8'd197, "R8 new result with intr", data_out, 197);
        chk(intr_n == 1'b0, "R8 intr with new result", intr_n, 0);
    endtask

    task automatic t_clear_paths;
        cs_n = 1'b1;
        rd_n = 1'b0;
        #1;
        chk(data_oe == 1'b0, "R11 no oe when deselected", data_oe, 0);
        adv(4);
        rd_n = 1'b1;
        adv(4);
        chk(intr_n == 1'b0, "R9 deselected read keeps intr", intr_n, 0);
        cs_n = 1'b0;
        adv(4);
        wr_drv = 1'b0;
        adv(2);
        chk(intr_n == 1'b0, "R10 intr before sync delay", intr_n, 0);
        adv(1);
        chk(intr_n == 1'b1, "R10 write clears intr", intr_n, 1);
        wr_drv = 1'b1;
        adv(1);
        adv(75);
    endtask

    task automatic t_collision;
        start_conv(8'd150, 8'd20);
        adv(68);
        rd_n = 1'b0;
        adv(3);
        chk(intr_n == 1'b0, "R12 done wins over read clear", intr_n, 0);
        chk(data_out == 8'd130, "R12 new result on collision", data_out, 130);
        rd_n = 1'b1;
        adv(6);
        chk(intr_n == 1'b0, "R12 intr stays low", intr_n, 0);
    endtask

    task automatic t_free_run;
        int gap;
        start_conv(8'd66, 8'd5);
        tie = 1'b1;
        gap = 0;
        while (intr_n == 1'b1 && gap < 200) begin adv(1); gap++; end
        chk(data_out == 8'd61, "R13 first free-run result", data_out, 61);
        gap = 0;
        while (intr_n == 1'b0 && gap < 200) begin adv(1); gap++; end
        vin_p = 8'd240; vin_n = 8'd15;
        while (intr_n == 1'b1 && gap < 200) begin adv(1); gap++; end
        chk(gap == 74, "R13 free-run period", gap, 74);
        chk(data_out == 8'd225, "R13 second free-run result", data_out, 225);
        tie = 1'b0;
        cs_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_hold_and_deselect();
        t_timed_conv(8'd200, 8'd50);
        t_timed_conv(8'd100, 8'd180);
        t_timed_conv(8'd255, 8'd0);
        t_quick_conv(8'd1, 8'd0);
        t_quick_conv(8'd42, 8'd42);
        t_hold_result();
        t_clear_paths();
        t_collision();
        t_free_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule